// File: doc/BRIEF.md
# Debug Word-Read Sequencer

This block sits on the host side of a debug scan link and pulls a run of consecutive 32-bit words out of target memory. The target already holds the start address in its first general register. A single `start` pulse with a nonzero `word_count` launches a fixed series of abstract scan operations. The operations select the data chain, place a load-to-debug-register instruction in the instruction register and issue it once. The sequencer then switches the data register to capture mode. Bit-level shifting is left to a separate scan engine, which the sequencer drives over a request/acknowledge handshake.

Issue and capture overlap. Each shift of the data register returns the word fetched by the previous load together with its Ready flag. The idle-state visit that follows then launches the next load. The last word is drained by shifts alone. The sequencer then selects the status chain, scans the status word out, which clears its sticky flags, and reports precise and imprecise abort indications with a one-cycle `done` pulse. Captured words leave on a simple valid/data stream in address order.

Top module: `dws_word_read_seq`

## Requirements
- R1: After an accepted start, the first five operations are: chain select carrying `DATA_CHAIN` (5), instruction-register select, instruction load carrying `LOAD_INSN`, one idle visit, and capture-mode select. The operation codes on `scan_op` are: 0 chain select, 1 instruction-register select, 2 instruction load, 3 capture-mode select, 4 data shift, 5 idle visit.
- R2: `scan_req` stays high with `scan_op` and `scan_wdata` unchanged until `scan_ack` is seen. It is low in the cycle after the acknowledge, so at most one operation is outstanding.
- R3: For a count N above 1, each data shift in the overlapped phase is followed by exactly one idle visit. The phase ends once N-1 shifts have returned Ready=1, so a target needing L not-ready shifts per load yields 1+(N-1)(L+1) idle visits in total.
- R4: For N equal to 1, the operation after capture-mode select is a data shift, and the only idle visit is the one in setup.
- R5: The final word is collected by repeated data shifts with no idle visit between them, until one returns Ready=1.
- R6: `out_valid` pulses once for each shift that returned Ready=1, with that shift's read data on `out_data`. Exactly N words appear, in address order.
- R7: After the last word, the operations are chain select carrying `STAT_CHAIN` (1), capture-mode select, and one data shift that reads the status word.
- R8: `abort_precise` reflects bit `PRECISE_BIT` (6) and `abort_imprecise` reflects bit `IMPRECISE_BIT` (7) of the status word. Both are valid when `done` pulses for one cycle, hold until the next accepted start, and are cleared by it.
- R9: A start pulse while a transfer is running, or one with `word_count` of 0, is ignored: no operation is issued and no `done` follows.
- R10: Under reset, `scan_req`, `out_valid`, `done`, `abort_precise` and `abort_imprecise` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| word_count | input | CNT_W | Number of words to read |
| scan_req | output | 1 | Scan operation request |
| scan_op | output | 3 | Operation code |
| scan_wdata | output | DW | Operand: chain number, instruction, or shift-in data |
| scan_ack | input | 1 | Scan engine finished the operation |
| scan_rdata | input | DW | Data shifted out by the operation |
| scan_ready | input | 1 | Ready flag captured by a data shift |
| out_valid | output | 1 | Captured word valid |
| out_data | output | DW | Captured word |
| done | output | 1 | One-cycle end-of-transfer pulse |
| abort_precise | output | 1 | Sticky precise abort was reported |
| abort_imprecise | output | 1 | Sticky imprecise abort was reported |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 16-bit count, data chain 5, status chain 1 and abort bits 6 and 7. It pairs the block with a behavioural target whose load latency can be set to 0 to 2 not-ready shifts. Word counts of 1, 4, 5 and 6 cover the skipped overlap loop, the retry path in both the loop and the drain, and exact counts of idle visits and total operations. Acknowledge delays of 0 to 3 cycles test the request hold, and status words with each abort bit set test the flag reporting and clearing.

// File: rtl/dws_pkg.sv
package dws_pkg;

  typedef enum logic [2:0] {
    OP_CHAIN  = 3'd0,
    OP_ITR    = 3'd1,
    OP_INSN   = 3'd2,
    OP_INTEST = 3'd3,
    OP_SHIFT  = 3'd4,
    OP_IDLE   = 3'd5
  } scan_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL_DATA,
    ST_SEL_ITR,
    ST_LOAD,
    ST_ISSUE,
    ST_INTEST,
    ST_LOOP_SHIFT,
    ST_LOOP_IDLE,
    ST_DRAIN,
    ST_SEL_STAT,
    ST_STAT_INTEST,
    ST_STAT_SHIFT,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/dws_scan_port.sv
module dws_scan_port
  import dws_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  scan_op_e      l_op,
  input  logic [DW-1:0] l_data,
  input  logic          scan_ack,
  input  logic [DW-1:0] scan_rdata,
  input  logic          scan_ready,
  output logic          scan_req,
  output logic [2:0]    scan_op,
  output logic [DW-1:0] scan_wdata,
  output logic          fin,
  output logic [DW-1:0] fin_rdata,
  output logic          fin_ready
);

  // One request in flight: operands frozen while req is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_req   <= 1'b0;
      scan_op    <= 3'd0;
      scan_wdata <= '0;
      fin        <= 1'b0;
      fin_rdata  <= '0;
      fin_ready  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (scan_req && scan_ack) begin
        scan_req  <= 1'b0;
        fin       <= 1'b1;
        fin_rdata <= scan_rdata;
        fin_ready <= scan_ready;
      end else if (launch && !scan_req) begin
        scan_req   <= 1'b1;
        scan_op    <= l_op;
        scan_wdata <= l_data;
      end
    end
  end

endmodule

// File: rtl/dws_word_tally.sv
module dws_word_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             more_than_one
);

  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= load_val;
    end else if (dec && remaining != '0) begin
      remaining <= remaining - 1'b1;
    end
  end

  assign more_than_one = (remaining > CNT_W'(1));

endmodule

// File: rtl/dws_abort_decode.sv
module dws_abort_decode (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic capture,
  input  logic precise_in,
  input  logic imprecise_in,
  output logic abort_precise,
  output logic abort_imprecise
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      abort_precise   <= 1'b0;
      abort_imprecise <= 1'b0;
    end else if (capture) begin
      abort_precise   <= precise_in;
      abort_imprecise <= imprecise_in;
    end
  end

endmodule

// File: rtl/dws_word_read_seq.sv
module dws_word_read_seq
  import dws_pkg::*;
#(
  parameter int          DW            = 32,
  parameter int          CNT_W         = 16,
  parameter int          DATA_CHAIN    = 5,
  parameter int          STAT_CHAIN    = 1,
  parameter int          PRECISE_BIT   = 6,
  parameter int          IMPRECISE_BIT = 7,
  parameter logic [31:0] LOAD_INSN     = 32'hECB0_5E01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] word_count,
  output logic             scan_req,
  output logic [2:0]       scan_op,
  output logic [DW-1:0]    scan_wdata,
  input  logic             scan_ack,
  input  logic [DW-1:0]    scan_rdata,
  input  logic             scan_ready,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             done,
  output logic             abort_precise,
  output logic             abort_imprecise
);

  localparam logic [DW-1:0] DATA_SEL = DW'(DATA_CHAIN);
  localparam logic [DW-1:0] STAT_SEL = DW'(STAT_CHAIN);
  localparam logic [DW-1:0] INSN_W   = DW'(LOAD_INSN);

  seq_state_e      state;
  logic            issued;
  logic            launch;
  scan_op_e        l_op;
  logic [DW-1:0]   l_data;
  logic            fin;
  logic [DW-1:0]   fin_rdata;
  logic            fin_ready;
  logic            accept;
  logic            emit;
  logic            more;
  logic            stat_capture;

  dws_scan_port #(.DW(DW)) u_port (
    .clk(clk), .rst(rst),
    .launch(launch), .l_op(l_op), .l_data(l_data),
    .scan_ack(scan_ack), .scan_rdata(scan_rdata), .scan_ready(scan_ready),
    .scan_req(scan_req), .scan_op(scan_op), .scan_wdata(scan_wdata),
    .fin(fin), .fin_rdata(fin_rdata), .fin_ready(fin_ready)
  );

  dws_word_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst),
    .load(accept), .load_val(word_count),
    .dec(emit), .more_than_one(more)
  );

  dws_abort_decode u_abort (
    .clk(clk), .rst(rst),
    .clr(accept), .capture(stat_capture),
    .precise_in(fin_rdata[PRECISE_BIT]),
    .imprecise_in(fin_rdata[IMPRECISE_BIT]),
    .abort_precise(abort_precise),
    .abort_imprecise(abort_imprecise)
  );

  assign accept       = (state == ST_IDLE) && start && (word_count != '0);
  assign emit         = fin && fin_ready &&
                        (state == ST_LOOP_SHIFT || state == ST_DRAIN);
  assign stat_capture = fin && (state == ST_STAT_SHIFT);

  // Operation chosen by the current step.
  always_comb begin
    l_op   = OP_SHIFT;
    l_data = '0;
    launch = !issued && (state != ST_IDLE) && (state != ST_DONE);
    unique case (state)
      ST_SEL_DATA:    begin l_op = OP_CHAIN;  l_data = DATA_SEL; end
      ST_SEL_ITR:     l_op = OP_ITR;
      ST_LOAD:        begin l_op = OP_INSN;   l_data = INSN_W;   end
      ST_ISSUE:       l_op = OP_IDLE;
      ST_INTEST:      l_op = OP_INTEST;
      ST_LOOP_SHIFT:  l_op = OP_SHIFT;
      ST_LOOP_IDLE:   l_op = OP_IDLE;
      ST_DRAIN:       l_op = OP_SHIFT;
      ST_SEL_STAT:    begin l_op = OP_CHAIN;  l_data = STAT_SEL; end
      ST_STAT_INTEST: l_op = OP_INTEST;
      ST_STAT_SHIFT:  l_op = OP_SHIFT;
      default:        l_op = OP_SHIFT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      issued    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      if (launch) issued <= 1'b1;
      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= fin_rdata;
      end
      unique case (state)
        ST_IDLE: if (accept) state <= ST_SEL_DATA;
        ST_DONE: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: if (fin) begin
          issued <= 1'b0;
          unique case (state)
            ST_SEL_DATA:    state <= ST_SEL_ITR;
            ST_SEL_ITR:     state <= ST_LOAD;
            ST_LOAD:        state <= ST_ISSUE;
            ST_ISSUE:       state <= ST_INTEST;
            ST_INTEST:      state <= more ? ST_LOOP_SHIFT : ST_DRAIN;
            ST_LOOP_SHIFT:  state <= ST_LOOP_IDLE;
            ST_LOOP_IDLE:   state <= more ? ST_LOOP_SHIFT : ST_DRAIN;
            ST_DRAIN:       if (fin_ready) state <= ST_SEL_STAT;
            ST_SEL_STAT:    state <= ST_STAT_INTEST;
            ST_STAT_INTEST: state <= ST_STAT_SHIFT;
            ST_STAT_SHIFT:  state <= ST_DONE;
            default:        state <= ST_IDLE;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/dws_wr_checker.sv
module dws_wr_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          scan_req,
  input logic [2:0]    scan_op,
  input logic [DW-1:0] scan_wdata,
  input logic          scan_ack,
  input logic          out_valid,
  input logic          done
);

  // R2: request and operands hold until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    (scan_req && !scan_ack) |=> (scan_req && $stable(scan_op) && $stable(scan_wdata)));

  // R2: request drops after its acknowledge
  a_r2_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    (scan_req && scan_ack) |=> !scan_req);

  // R6: words are emitted only between operations
  a_r6_emit_quiet: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !scan_req);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: done never coincides with a word or a pending operation
  a_r8_done_alone: assert property (@(posedge clk) disable iff (rst)
    done |-> (!out_valid && !scan_req));

endmodule

bind dws_word_read_seq dws_wr_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .scan_req(scan_req), .scan_op(scan_op),
  .scan_wdata(scan_wdata), .scan_ack(scan_ack),
  .out_valid(out_valid), .done(done)
);

// File: tb/dws_word_read_seq_tb.sv
module dws_word_read_seq_tb;

  localparam int DW = 32;
  localparam int CW = 16;
  localparam logic [31:0] INSN = 32'hECB0_5E01;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] word_count = '0;
  logic          scan_req;
  logic [2:0]    scan_op;
  logic [DW-1:0] scan_wdata;
  logic          scan_ack = 1'b0;
  logic [DW-1:0] scan_rdata = '0;
  logic          scan_ready = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          done;
  logic          abort_precise;
  logic          abort_imprecise;

  always #4 clk = ~clk;

  dws_word_read_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .word_count(word_count),
    .scan_req(scan_req), .scan_op(scan_op), .scan_wdata(scan_wdata),
    .scan_ack(scan_ack), .scan_rdata(scan_rdata), .scan_ready(scan_ready),
    .out_valid(out_valid), .out_data(out_data), .done(done),
    .abort_precise(abort_precise), .abort_imprecise(abort_imprecise)
  );

  int n_chk = 0;
  int n_bad = 0;

  // target model
  int          t_chain, t_r0, t_infl, t_loads, t_lat, ack_dly, wcnt;
  bit          t_cons;
  logic [31:0] t_held, t_stat, salt;
  logic [2:0]  lg_op [0:255];
  logic [31:0] lg_dat[0:255];
  int          nlog;
  int          viol;
  logic [2:0]  pend_op;
  logic [31:0] pend_dat;
  bit          pend;
  logic [31:0] rx_dat[0:63];
  int          nrx, ndone;

  function automatic logic [31:0] mword(int a);
    return 32'hA500_0000 ^ (a * 32'h0001_0203) ^ salt;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op();
    if (nlog < 256) begin lg_op[nlog] = scan_op; lg_dat[nlog] = scan_wdata; end
    nlog++;
    scan_ready = 1'b0;
    scan_rdata = 32'hDEAD_BEEF;
    case (scan_op)
      3'd0: t_chain = int'(scan_wdata);
      3'd5: if (t_chain == 5 && t_cons) begin
              t_held = mword(t_r0); t_r0++; t_infl = t_lat; t_cons = 0; t_loads++;
            end
      3'd4: begin
        if (t_chain == 1) begin scan_rdata = t_stat; scan_ready = 1'b1; end
        else if (!t_cons && t_infl > 0) t_infl--;
        else if (!t_cons) begin scan_rdata = t_held; scan_ready = 1'b1; t_cons = 1; end
      end
      default: ;
    endcase
  endtask

  // scan engine responder
  initial begin
    wcnt = 0; viol = 0; pend = 0;
    forever begin
      @(negedge clk);
      if (scan_ack) begin
        scan_ack = 1'b0;
        pend = 0;
        if (scan_req) viol++;
      end else if (scan_req) begin
        if (pend && (scan_op != pend_op || scan_wdata != pend_dat)) viol++;
        pend = 1; pend_op = scan_op; pend_dat = scan_wdata;
        if (wcnt < (nlog % (ack_dly + 1))) wcnt++;
        else begin wcnt = 0; do_op(); scan_ack = 1'b1; end
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (nrx < 64) rx_dat[nrx] = out_data;
        nrx++;
      end
      if (done) ndone++;
    end
  end

  task automatic model_reset(input int lat, input int dly, input logic [31:0] stat);
    t_chain = 0; t_r0 = 16; t_infl = 0; t_loads = 0; t_cons = 1;
    t_lat = lat; ack_dly = dly; t_stat = stat;
    nlog = 0; nrx = 0; ndone = 0;
  endtask

  task automatic do_read(input int n, input int lat, input int dly,
                         input logic [31:0] stat, input bit intrude, input string tag);
    int t;
    int exp_total;
    int exp_idle;
    int n_idle;
    salt = 32'(n * 977 + lat);
    model_reset(lat, dly, stat);
    @(negedge clk); start = 1'b1; word_count = CW'(n);
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(!abort_precise && !abort_imprecise, {tag, " R8 flags cleared on start"},
          {30'd0, abort_precise, abort_imprecise}, 0);
    if (intrude) begin
      repeat (6) @(negedge clk);
      start = 1'b1; word_count = CW'(7);
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (ndone == 0 && t < 5000) begin @(negedge clk); t++; end
    check(ndone == 1, {tag, " R8 done seen"}, ndone, 1);
    exp_total = 5 + 2 * (n - 1) * (lat + 1) + (lat + 1) + 3;
    exp_idle  = 1 + (n - 1) * (lat + 1);
    check(nlog == exp_total, {tag, " R3 total operations"}, nlog, exp_total);
    n_idle = 0;
    for (int i = 0; i < nlog && i < 256; i++) if (lg_op[i] == 3'd5) n_idle++;
    check(n_idle == exp_idle, {tag, " R3 idle visits"}, n_idle, exp_idle);
    check(lg_op[0] == 3'd0 && lg_dat[0] == 5 && lg_op[1] == 3'd1 &&
          lg_op[2] == 3'd2 && lg_dat[2] == INSN && lg_op[3] == 3'd5 && lg_op[4] == 3'd3,
          {tag, " R1 setup order"}, {29'd0, lg_op[2]}, 2);
    check(lg_op[5] == 3'd4, {tag, " R4/R3 first op after capture select is shift"},
          lg_op[5], 4);
    for (int i = 0; i <= lat; i++)
      check(lg_op[nlog - 4 - i] == 3'd4, {tag, " R5 drain shifts without idle"},
            lg_op[nlog - 4 - i], 4);
    check(lg_op[nlog-3] == 3'd0 && lg_dat[nlog-3] == 1 && lg_op[nlog-2] == 3'd3 &&
          lg_op[nlog-1] == 3'd4, {tag, " R7 status sequence"}, lg_dat[nlog-3], 1);
    check(nrx == n && t_loads == n, {tag, " R6 word count"}, nrx, n);
    for (int i = 0; i < n && i < 64; i++)
      check(rx_dat[i] == mword(16 + i), {tag, " R6 word data"}, rx_dat[i], mword(16 + i));
    check(abort_precise == stat[6] && abort_imprecise == stat[7], {tag, " R8 abort flags"},
          {30'd0, abort_precise, abort_imprecise}, {30'd0, stat[6], stat[7]});
    check(viol == 0, {tag, " R2 handshake"}, viol, 0);
    repeat (4) @(negedge clk);
    check(ndone == 1 && abort_precise == stat[6] && abort_imprecise == stat[7] && !scan_req,
          {tag, " R8/R9 flags held, single done, no extra run"}, ndone, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    salt = 0;
    model_reset(0, 0, 0);
    repeat (3) @(negedge clk);
    check(!scan_req && !out_valid && !done && !abort_precise && !abort_imprecise,
          "R10 reset state", {27'd0, scan_req, out_valid, done, abort_precise, abort_imprecise}, 0);
    rst = 1'b0;
    @(negedge clk);

    do_read(1, 0, 0, 32'h0, 1'b0, "single word");
    do_read(1, 2, 1, 32'h0, 1'b0, "single word slow");
    do_read(4, 0, 0, 32'h0, 1'b0, "four words");
    do_read(5, 2, 3, 32'h0, 1'b0, "five words slow");
    do_read(4, 1, 2, 32'h0000_0040, 1'b0, "precise abort");
    do_read(3, 0, 1, 32'h0000_0080, 1'b0, "imprecise abort");
    do_read(6, 1, 1, 32'h0, 1'b1, "R9 start while busy");

    model_reset(0, 0, 0);
    @(negedge clk); start = 1'b1; word_count = '0;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    check(nlog == 0 && ndone == 0, "R9 zero count ignored", nlog, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule